// File: doc/BRIEF.md
# Refresh Request Interval Timer

This block paces dynamic memory refresh. A 9-bit down counter runs once per clock while the block is enabled. Each time the counter reaches one, it raises a refresh request and reloads itself from a software-written period. A bus agent outside the block serves the request and returns an acknowledge that clears it. The counter does not wait for that service, so requests keep a fixed spacing however busy the bus is. If the next request falls due while the previous one is still unserved, the new one is dropped. A one-cycle pulse shows each drop.

Software uses two registers, chosen by a one-bit select. The period register (select 0) holds the reload value. The control register (select 1) holds the enable flag and returns the live count when read. Arbitration for the bus and the generation of the refresh address belong to other blocks.

Top module: `rfsh_req_timer`

## Requirements
- R1: While enabled, the counter drops by one each clock. When it holds 1, it reloads from the period register on that clock and raises the request. With period N (1..511), the request rises N clock edges after the edge that enabled the block, and every N edges after that.
- R2: A period value of 0 gives a spacing of 512 clock edges between requests.
- R3: A control write with bit 15 set always loads the period into the counter, even when the block is already enabled. The next request then comes N edges after that write.
- R4: A new period written while counting does not disturb the current countdown. It is used from the next reload on.
- R5: A control write with bit 15 clear disables the block and zeroes the counter. No new request is raised while disabled, and the count field reads as zero.
- R6: The request stays high until an acknowledge is sampled, and the acknowledge clears it. If a new request falls due in the same cycle as the acknowledge, the request stays high.
- R7: The counter keeps running while a request is pending. A request that falls due while the previous one is pending and not being acknowledged is lost. `req_dropped` goes high for exactly one cycle, on the cycle after the edge where the request fell due.
- R8: Reads are combinational while `reg_rd` is high; otherwise `reg_rdata` is zero. Select 0 returns the period in bits 8..0. Select 1 returns the enable flag in bit 15 and the count in bits 8..0. All other bits read as zero. Count bits written to the control register are ignored.
- R9: Reset clears the period, the enable flag, the counter and the request. No request is raised during reset or after it until the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 period, 1 control |
| reg_wdata | input | 16 | Write data |
| svc_ack | input | 1 | Service acknowledge, clears the pending request |
| rfsh_req | output | 1 | Pending refresh request |
| req_dropped | output | 1 | One-cycle pulse when a request is lost |
| reg_rdata | output | 16 | Read data |

## Verification
A wrong reload or an off-by-one at the terminal count shows up at once as a request edge that comes too early or too late. The bench measures the spacing for every period from 0 to 24, plus 255 and 511. An enable or period write handled wrongly moves the first request after the write. A stuck count register shows through the control read within a few cycles. A request that is not held, or a drop that is not detected, shows at `rfsh_req` and `req_dropped` one full period after the first unserved request.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    localparam int CNT_W   = 9;
    localparam int DATA_W  = 16;
    localparam int EN_BIT  = DATA_W - 1;
    localparam int PAD_W   = EN_BIT - CNT_W;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        SEL_PERIOD = 1'b0,
        SEL_CTRL   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic reload;
        logic stop;
    } cnt_cmd_t;

    function automatic word_t pack_period(cnt_t p);
        return {{(DATA_W-CNT_W){1'b0}}, p};
    endfunction

    function automatic word_t pack_ctrl(logic en, cnt_t c);
        return {en, {PAD_W{1'b0}}, c};
    endfunction
endpackage

// File: rtl/rfsh_regfile.sv
module rfsh_regfile
    import rfsh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  reg_sel_e sel,
    input  word_t    wdata,
    output cnt_t     period,
    output logic     enabled,
    output cnt_cmd_t cmd
);
    logic unused_wbits;
    assign unused_wbits = ^wdata[EN_BIT-1:CNT_W];

    logic ctrl_wr;
    assign ctrl_wr    = wr && (sel == SEL_CTRL);
    assign cmd.reload = ctrl_wr &&  wdata[EN_BIT];
    assign cmd.stop   = ctrl_wr && !wdata[EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            period  <= '0;
            enabled <= 1'b0;
        end else begin
            if (wr && sel == SEL_PERIOD) period <= wdata[CNT_W-1:0];
            if (ctrl_wr) enabled <= wdata[EN_BIT];
        end
    end
endmodule

// File: rtl/rfsh_downcnt.sv
module rfsh_downcnt
    import rfsh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enabled,
    input  cnt_cmd_t cmd,
    input  cnt_t     period,
    output cnt_t     count,
    output logic     due
);
    localparam cnt_t ONE = cnt_t'(1);

    assign due = enabled && !cmd.reload && !cmd.stop && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst || cmd.stop) begin
            count <= '0;
        end else if (cmd.reload || due) begin
            count <= period;
        end else if (enabled) begin
            count <= count - ONE;
        end
    end
endmodule

// File: rtl/rfsh_req_hold.sv
module rfsh_req_hold (
    input  logic clk,
    input  logic rst,
    input  logic due,
    input  logic ack,
    output logic req,
    output logic dropped
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= 1'b0;
            dropped <= 1'b0;
        end else begin
            dropped <= due && req && !ack;
            if (due)      req <= 1'b1;
            else if (ack) req <= 1'b0;
        end
    end
endmodule

// File: rtl/rfsh_req_timer.sv
module rfsh_req_timer
    import rfsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              svc_ack,
    output logic              rfsh_req,
    output logic              req_dropped,
    output logic [DATA_W-1:0] reg_rdata
);
    cnt_t     period_q;
    cnt_t     cnt_q;
    logic     en_q;
    logic     due;
    cnt_cmd_t cmd;
    reg_sel_e sel;

    assign sel = reg_sel_e'(reg_sel);

    rfsh_regfile u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(sel), .wdata(reg_wdata),
        .period(period_q), .enabled(en_q), .cmd(cmd)
    );

    rfsh_downcnt u_cnt (
        .clk(clk), .rst(rst), .enabled(en_q), .cmd(cmd), .period(period_q),
        .count(cnt_q), .due(due)
    );

    rfsh_req_hold u_req (
        .clk(clk), .rst(rst), .due(due), .ack(svc_ack),
        .req(rfsh_req), .dropped(req_dropped)
    );

    always_comb begin
        if (!reg_rd)                reg_rdata = '0;
        else if (sel == SEL_PERIOD) reg_rdata = pack_period(period_q);
        else                        reg_rdata = pack_ctrl(en_q, cnt_q);
    end
endmodule

// File: rtl/rfsh_timer_checker.sv
module rfsh_timer_checker
    import rfsh_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic        reg_sel,
    input logic        svc_ack,
    input logic        rfsh_req,
    input logic        req_dropped,
    input logic [15:0] reg_rdata,
    input logic        en,
    input cnt_t        cnt
);
    logic ctrl_wr;
    assign ctrl_wr = reg_wr && reg_sel;

    a_r1_countdown: assert property (@(posedge clk) disable iff (rst)
        (en && cnt > cnt_t'(1) && !ctrl_wr) |=> (cnt == $past(cnt) - cnt_t'(1)));

    a_r1_due_raises_req: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == cnt_t'(1) && !ctrl_wr) |=> rfsh_req);

    a_r5_off_count_zero: assert property (@(posedge clk) disable iff (rst)
        !en |-> (cnt == '0));

    a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
        (rfsh_req && !svc_ack) |=> rfsh_req);

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (rfsh_req && svc_ack && !(en && cnt == cnt_t'(1)) && !ctrl_wr) |=> !rfsh_req);

    a_r7_drop_needs_pending: assert property (@(posedge clk) disable iff (rst)
        req_dropped |-> $past(rfsh_req));

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> (reg_rdata[14:9] == '0));
endmodule

bind rfsh_req_timer rfsh_timer_checker u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .svc_ack(svc_ack), .rfsh_req(rfsh_req), .req_dropped(req_dropped),
    .reg_rdata(reg_rdata), .en(en_q), .cnt(cnt_q)
);

// File: tb/test_rfsh_req_timer.sv
`timescale 1ns/100ps
module test_rfsh_req_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        svc_ack = 1'b0;
    logic        rfsh_req;
    logic        req_dropped;
    logic [15:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    int drops  = 0;
    int rises  = 0;
    logic prev_req = 1'b0;

    always #2.5 clk = ~clk;

    rfsh_req_timer i_rfsh_req_timer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .svc_ack(svc_ack), .rfsh_req(rfsh_req),
        .req_dropped(req_dropped), .reg_rdata(reg_rdata)
    );

    task automatic step();
        @(negedge clk);
        edges++;
        if (req_dropped) drops++;
        if (rfsh_req && !prev_req) rises++;
        prev_req = rfsh_req;
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write(logic sel, logic [15:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic read(logic sel, output int v);
        reg_rd = 1'b1; reg_sel = sel;
        #0.5;
        v = int'(reg_rdata);
        reg_rd = 1'b0;
        #0.5;
    endtask

    task automatic wait_req(int limit);
        while (!rfsh_req && edges < limit) step();
    endtask

    task automatic ack_pulse();
        svc_ack = 1'b1; step(); svc_ack = 1'b0;
    endtask

    task automatic shut_down();
        write(1'b1, 16'h0000);
        ack_pulse();
    endtask

    task automatic run_period(int p);
        int exp_n;
        exp_n = (p == 0) ? 512 : p;
        write(1'b0, 16'(p));
        write(1'b1, 16'h8000);
        edges = 0;
        wait_req(4000);
        check((p == 0) ? "R2 first interval" : "R1 first interval", edges, exp_n);
        ack_pulse();
        wait_req(4000);
        check((p == 0) ? "R2 second interval" : "R1 second interval", edges, 2 * exp_n);
        shut_down();
    endtask

    initial begin : watchdog
        #500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int v;
        @(negedge clk);
        step(); step();
        // R9: state during and after reset
        check("R9 req in reset", int'(rfsh_req), 0);
        rst = 1'b0;
        step();
        read(1'b0, v); check("R9 period reset", v, 0);
        read(1'b1, v); check("R9 ctrl reset", v, 0);
        check("R9 req after reset", int'(rfsh_req), 0);

        // R1 / R2: interval sweep
        for (int p = 0; p <= 24; p++) run_period(p);
        run_period(255);
        run_period(511);

        // R1: live count readback
        write(1'b0, 16'd9);
        write(1'b1, 16'h8000);
        read(1'b1, v); check("R1 count after load", v, 16'h8009);
        step(); step(); step();
        read(1'b1, v); check("R1 count after 3", v, 16'h8006);
        shut_down();

        // R3: re-enable reloads
        write(1'b0, 16'd10);
        write(1'b1, 16'h8000);
        edges = 0;
        repeat (5) step();
        write(1'b1, 16'h8000);
        wait_req(100);
        check("R3 reload on re-enable", edges, 16);
        shut_down();

        // R4: new period used only at next reload
        write(1'b0, 16'd10);
        write(1'b1, 16'h8000);
        edges = 0;
        repeat (3) step();
        write(1'b0, 16'd4);
        wait_req(100);
        check("R4 current countdown kept", edges, 10);
        ack_pulse();
        wait_req(100);
        check("R4 new period after reload", edges, 14);
        shut_down();

        // R7 / R6: drops while pending, counting continues
        write(1'b0, 16'd4);
        write(1'b1, 16'h8000);
        edges = 0; drops = 0;
        begin
            int lost_hold = 0;
            while (edges < 12) begin
                step();
                if (edges >= 4 && !rfsh_req) lost_hold++;
            end
            check("R6 req held while pending", lost_hold, 0);
        end
        check("R7 drop pulses", drops, 2);
        read(1'b1, v); check("R7 count keeps running", v, 16'h8004);
        ack_pulse();
        check("R6 ack clears", int'(rfsh_req), 0);
        wait_req(100);
        check("R7 interval unchanged", edges, 16);
        check("R7 no extra drop", drops, 2);
        shut_down();

        // R6: due in the same cycle as ack keeps req high
        write(1'b0, 16'd1);
        write(1'b1, 16'h8000);
        step();
        ack_pulse();
        check("R6 due with ack keeps req", int'(rfsh_req), 1);
        shut_down();

        // R5: disable stops everything
        write(1'b0, 16'd6);
        write(1'b1, 16'h8000);
        repeat (3) step();
        write(1'b1, 16'h0000);
        read(1'b1, v); check("R5 ctrl reads zero when off", v, 0);
        rises = 0;
        repeat (600) step();
        check("R5 no request while off", rises, 0);

        // R8: register map
        write(1'b1, 16'h01FF);
        read(1'b1, v); check("R8 count write ignored", v, 0);
        write(1'b0, 16'hFFFF);
        read(1'b0, v); check("R8 period upper bits zero", v, 16'h01FF);
        reg_sel = 1'b0; #0.5;
        check("R8 no read strobe gives zero", int'(reg_rdata), 0);
        write(1'b1, 16'hFFFF);
        read(1'b1, v); check("R8 ctrl layout", v, 16'h81FF);
        shut_down();

        // R9: reset in mid-run
        write(1'b0, 16'd5);
        write(1'b1, 16'h8000);
        step(); step();
        rst = 1'b1; step(); step(); rst = 1'b0;
        rises = 0;
        repeat (20) step();
        check("R9 no request after reset", rises, 0);
        read(1'b1, v); check("R9 ctrl cleared", v, 0);
        read(1'b0, v); check("R9 period cleared", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule